// File: doc/BRIEF.md
# Inhibit-Line Sample Synchronizer

The block watches one asynchronous control line that has two jobs. A long high level on it means "hold off charging". Short high pulses on it are timing marks that tell the voltage sampler when to take a reading. The two uses are told apart only by how long the line stays high. The block first brings the line into the clock domain, then measures each high interval. It measures in two units: clock cycles, which set the glitch floor, and timebase ticks, which set the sync ceiling and the inhibit threshold.

A short pulse of acceptable width produces a one-cycle sample strobe after its falling edge. A level held past the inhibit threshold raises a sustained inhibit flag and asks the sample history to be cleared. Widths that are too short, or that fall in the band between the two classes, are dropped without any effect.

While sync pulses keep arriving often enough, the block reports itself synchronized. When the gap since the last accepted pulse reaches the limit chosen by the mode input, it falls back to free-running strobes at a fixed tick interval. Leaving free-run for synchronized operation always starts with a history-clear request.

Top module: `inh_pulse_sync`

## Requirements
- R1: While and right after reset, `sample_stb`, `clear_hist`, `inhibit_active` and `synced` are all 0.
- R2: While synchronized, a high pulse of at least MIN_CLKS clock cycles and at most SYNC_MAX_TICKS ticks yields exactly one `sample_stb` pulse, issued after its falling edge.
- R3: While free-running, the first such valid pulse yields one `clear_hist` pulse and sets `synced` to 1, with no `sample_stb` for that pulse.
- R4: A high pulse shorter than MIN_CLKS clock cycles causes no strobe, no clear and no change of `synced`.
- R5: A high pulse longer than SYNC_MAX_TICKS ticks that ends before LONG_TICKS ticks causes no strobe, no clear and no change of `synced`.
- R6: When a high level reaches LONG_TICKS ticks, `inhibit_active` goes to 1 and `synced` goes to 0. One `clear_hist` pulse follows one cycle later. `inhibit_active` returns to 0 once the synchronized line is low.
- R7: While synchronized, `synced` drops to 0 when no accepted pulse has arrived for the mode's gap limit. The limit is GAP_LIM0 ticks for mode 0, GAP_LIM1 for mode 1, and GAP_LIM2 for modes 2 and 3.
- R8: While not synchronized, `sample_stb` pulses once every FREE_TICKS ticks, counted from reset or from the fallback.
- R9: `sample_stb` and `clear_hist` are single-cycle pulses.
- R10: The width counter saturates. A high level held for any length past LONG_TICKS yields only one `clear_hist`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| inh_async | input | 1 | Raw inhibit / sync line, asynchronous |
| tick | input | 1 | One-cycle timebase tick |
| mode | input | 2 | Selects the gap limit for synchronized operation |
| sample_stb | output | 1 | One-cycle request to take a voltage sample |
| clear_hist | output | 1 | One-cycle request to erase the sample history |
| inhibit_active | output | 1 | High while a sustained inhibit level is present |
| synced | output | 1 | 1 = synchronized sampling, 0 = free-running |

## Verification
The assertions check, on every cycle, the relations among the outputs:
- strobes and clears last a single cycle;
- every entry into synchronized mode comes with a clear;
- an inhibit onset is followed by exactly one clear;
- `synced` stays low while inhibit is held.

Only the bench scenarios can show the parts that depend on measured durations:
- the width classification (glitch, middle band, sync, long);
- the gap limit picked by each mode value;
- the exact free-run strobe period.

// File: rtl/inh_pulse_sync_pkg.sv
package inh_pulse_sync_pkg;
  // Result of measuring one high interval, produced by the width stage.
  typedef struct packed {
    logic sync_ok;   // valid sync pulse just ended
    logic long_hit;  // high level reached the inhibit threshold
  } width_ev_t;

  function automatic int max3(input int a, input int b, input int c);
    int m;
    m = (a > b) ? a : b;
    return (m > c) ? m : c;
  endfunction
endpackage

// File: rtl/ips_sync.sv
module ips_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic async_in,
  output logic level,
  output logic fall
);
  logic [STAGES-1:0] chain;
  logic              prev;

  always_ff @(posedge clk) begin
    if (rst) begin
      chain <= '0;
      prev  <= 1'b0;
    end else begin
      chain <= {chain[STAGES-2:0], async_in};
      prev  <= chain[STAGES-1];
    end
  end

  assign level = chain[STAGES-1];
  assign fall  = prev & ~chain[STAGES-1];
endmodule

// File: rtl/ips_width.sv
module ips_width
  import inh_pulse_sync_pkg::*;
#(
  parameter int MIN_CLKS       = 20,
  parameter int SYNC_MAX_TICKS = 35,
  parameter int LONG_TICKS     = 120
) (
  input  logic      clk,
  input  logic      rst,
  input  logic      level,
  input  logic      fall,
  input  logic      tick,
  output width_ev_t ev,
  output logic      long_hold
);
  localparam int CW = $clog2(MIN_CLKS + 1);
  localparam int TW = $clog2(LONG_TICKS + 1);

  logic [CW-1:0] hi_clks;
  logic [TW-1:0] hi_ticks;
  logic          wide_enough;
  logic          short_enough;

  assign wide_enough  = (hi_clks == CW'(MIN_CLKS));
  assign short_enough = (hi_ticks <= TW'(SYNC_MAX_TICKS));

  always_ff @(posedge clk) begin
    if (rst) begin
      hi_clks   <= '0;
      hi_ticks  <= '0;
      ev        <= '0;
      long_hold <= 1'b0;
    end else begin
      ev <= '0;
      if (level) begin
        if (!wide_enough) hi_clks <= hi_clks + 1'b1;
        if (tick && hi_ticks != TW'(LONG_TICKS)) begin
          hi_ticks <= hi_ticks + 1'b1;
          if (hi_ticks == TW'(LONG_TICKS - 1)) begin
            ev.long_hit <= 1'b1;
            long_hold   <= 1'b1;
          end
        end
      end else begin
        hi_clks   <= '0;
        hi_ticks  <= '0;
        long_hold <= 1'b0;
        if (fall && wide_enough && short_enough) ev.sync_ok <= 1'b1;
      end
    end
  end
endmodule

// File: rtl/ips_period.sv
module ips_period
  import inh_pulse_sync_pkg::*;
#(
  parameter int FREE_TICKS = 170000,
  parameter int GAP_LIM0   = 187000,
  parameter int GAP_LIM1   = 187000,
  parameter int GAP_LIM2   = 94000
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       tick,
  input  logic [1:0] mode,
  input  width_ev_t  ev,
  output logic       sample_stb,
  output logic       clear_hist,
  output logic       synced
);
  localparam int GW = $clog2(max3(GAP_LIM0, GAP_LIM1, GAP_LIM2) + 1);
  localparam int FW = $clog2(FREE_TICKS + 1);

  logic [GW-1:0] gap_cnt;
  logic [GW-1:0] gap_lim;
  logic [FW-1:0] free_cnt;

  always_comb begin
    case (mode)
      2'd0:    gap_lim = GW'(GAP_LIM0);
      2'd1:    gap_lim = GW'(GAP_LIM1);
      default: gap_lim = GW'(GAP_LIM2);
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      gap_cnt    <= '0;
      free_cnt   <= '0;
      sample_stb <= 1'b0;
      clear_hist <= 1'b0;
      synced     <= 1'b0;
    end else begin
      sample_stb <= 1'b0;
      clear_hist <= 1'b0;
      if (ev.long_hit) begin
        synced     <= 1'b0;
        clear_hist <= 1'b1;
        free_cnt   <= '0;
      end else if (ev.sync_ok) begin
        gap_cnt <= '0;
        if (!synced) begin
          synced     <= 1'b1;
          clear_hist <= 1'b1;
        end else begin
          sample_stb <= 1'b1;
        end
      end else if (synced) begin
        if (tick) begin
          if (gap_cnt >= gap_lim - 1'b1) begin
            synced   <= 1'b0;
            free_cnt <= '0;
          end else begin
            gap_cnt <= gap_cnt + 1'b1;
          end
        end
      end else if (tick) begin
        if (free_cnt == FW'(FREE_TICKS - 1)) begin
          sample_stb <= 1'b1;
          free_cnt   <= '0;
        end else begin
          free_cnt <= free_cnt + 1'b1;
        end
      end
    end
  end
endmodule

// File: rtl/inh_pulse_sync.sv
module inh_pulse_sync
  import inh_pulse_sync_pkg::*;
#(
  parameter int SYNC_STAGES    = 2,
  parameter int MIN_CLKS       = 20,
  parameter int SYNC_MAX_TICKS = 35,
  parameter int LONG_TICKS     = 120,
  parameter int FREE_TICKS     = 170000,
  parameter int GAP_LIM0       = 187000,
  parameter int GAP_LIM1       = 187000,
  parameter int GAP_LIM2       = 94000
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       inh_async,
  input  logic       tick,
  input  logic [1:0] mode,
  output logic       sample_stb,
  output logic       clear_hist,
  output logic       inhibit_active,
  output logic       synced
);
  logic      line_lvl;
  logic      line_fall;
  width_ev_t wev;

  ips_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst(rst), .async_in(inh_async),
    .level(line_lvl), .fall(line_fall)
  );

  ips_width #(
    .MIN_CLKS(MIN_CLKS), .SYNC_MAX_TICKS(SYNC_MAX_TICKS), .LONG_TICKS(LONG_TICKS)
  ) u_width (
    .clk(clk), .rst(rst), .level(line_lvl), .fall(line_fall), .tick(tick),
    .ev(wev), .long_hold(inhibit_active)
  );

  ips_period #(
    .FREE_TICKS(FREE_TICKS), .GAP_LIM0(GAP_LIM0), .GAP_LIM1(GAP_LIM1), .GAP_LIM2(GAP_LIM2)
  ) u_period (
    .clk(clk), .rst(rst), .tick(tick), .mode(mode), .ev(wev),
    .sample_stb(sample_stb), .clear_hist(clear_hist), .synced(synced)
  );
endmodule

// File: rtl/inh_pulse_sync_chk.sv
module inh_pulse_sync_chk (
  input logic clk,
  input logic rst,
  input logic sample_stb,
  input logic clear_hist,
  input logic inhibit_active,
  input logic synced
);
  AST_SAMPLE_SINGLE: assert property (@(posedge clk) disable iff (rst)
    sample_stb |=> !sample_stb); // R9

  AST_CLEAR_SINGLE: assert property (@(posedge clk) disable iff (rst)
    clear_hist |=> !clear_hist); // R9

  AST_SYNC_ENTRY_CLEARS: assert property (@(posedge clk) disable iff (rst)
    $rose(synced) |-> clear_hist); // R3

  AST_INHIBIT_THEN_CLEAR: assert property (@(posedge clk) disable iff (rst)
    $rose(inhibit_active) |=> clear_hist); // R6

  AST_INHIBIT_UNSYNCED: assert property (@(posedge clk) disable iff (rst)
    (inhibit_active && $past(inhibit_active)) |-> !synced); // R6

  AST_HELD_NO_REPEAT_CLEAR: assert property (@(posedge clk) disable iff (rst)
    (inhibit_active && $past(inhibit_active) && $past(inhibit_active, 2)) |-> !clear_hist); // R10
endmodule

bind inh_pulse_sync inh_pulse_sync_chk u_chk (
  .clk(clk), .rst(rst), .sample_stb(sample_stb), .clear_hist(clear_hist),
  .inhibit_active(inhibit_active), .synced(synced)
);

// File: tb/inh_pulse_sync_test.sv
`timescale 1ns/1ps
module inh_pulse_sync_test;
  localparam int TICK_DIV = 10;
  localparam int FREE_T   = 60;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic inh = 1'b0;
  logic tick = 1'b0;
  logic [1:0] mode = 2'd2;
  logic sample_stb, clear_hist, inhibit_active, synced;

  int checks = 0;
  int errors = 0;
  int cyc = 0;
  int last_s = 0;
  int prev_s = 0;
  byte exp_kind[$];
  string exp_req[$];

  always #2.5 clk = ~clk;

  inh_pulse_sync #(
    .MIN_CLKS(4), .SYNC_MAX_TICKS(4), .LONG_TICKS(12), .FREE_TICKS(FREE_T),
    .GAP_LIM0(8), .GAP_LIM1(16), .GAP_LIM2(30)
  ) uut (
    .clk(clk), .rst(rst), .inh_async(inh), .tick(tick), .mode(mode),
    .sample_stb(sample_stb), .clear_hist(clear_hist),
    .inhibit_active(inhibit_active), .synced(synced)
  );

  initial begin
    int n = 0;
    forever begin
      @(negedge clk);
      n = (n == TICK_DIV - 1) ? 0 : n + 1;
      tick = (n == 0);
    end
  end

  task automatic expect_ev(input byte k, input string req);
    exp_kind.push_back(k);
    exp_req.push_back(req);
  endtask

  task automatic got_ev(input byte k);
    checks++;
    if (exp_kind.size() == 0) begin
      errors++;
      $display("FAIL unexpected event: actual %s expected none (R2 R4 R5 R10)", k);
    end else begin
      byte e;
      string r;
      e = exp_kind.pop_front();
      r = exp_req.pop_front();
      if (e != k) begin
        errors++;
        $display("FAIL %s event: actual %s expected %s", r, k, e);
      end
    end
  endtask

  // monitor: scoreboard compare, strobe timestamps, watchdog
  always @(negedge clk) begin
    cyc++;
    if (!rst) begin
      if (clear_hist) got_ev("C");
      if (sample_stb) begin
        got_ev("S");
        prev_s = last_s;
        last_s = cyc;
      end
    end
    if (cyc > 150000) begin
      errors++;
      $display("FAIL watchdog: actual %0d cycles expected under 150000", cyc);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  task automatic drained(input string req);
    checks++;
    if (exp_kind.size() != 0) begin
      errors++;
      $display("FAIL %s missing events: actual %0d pending expected 0", req, exp_kind.size());
    end
    exp_kind.delete();
    exp_req.delete();
  endtask

  task automatic check_bit(input string req, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %b expected %b", req, act, exp);
    end
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst = 1'b1;
    inh = 1'b0;
    repeat (3) @(negedge clk);
    exp_kind.delete();
    exp_req.delete();
    rst = 1'b0;
  endtask

  task automatic pulse(input int hi, input int lo);
    @(negedge clk);
    inh = 1'b1;
    repeat (hi) @(negedge clk);
    inh = 1'b0;
    repeat (lo) @(negedge clk);
  endtask

  initial begin
    // R1 reset state
    do_reset();
    check_bit("R1 sample_stb", sample_stb, 1'b0);
    check_bit("R1 clear_hist", clear_hist, 1'b0);
    check_bit("R1 inhibit_active", inhibit_active, 1'b0);
    check_bit("R1 synced", synced, 1'b0);

    // R8 free-running period
    do_reset();
    expect_ev("S", "R8");
    expect_ev("S", "R8");
    repeat (1250) @(negedge clk);
    drained("R8");
    checks++;
    if (last_s - prev_s != FREE_T * TICK_DIV) begin
      errors++;
      $display("FAIL R8 period: actual %0d expected %0d", last_s - prev_s, FREE_T * TICK_DIV);
    end

    // R3 entry into sync, then R2 strobes
    do_reset();
    expect_ev("C", "R3");
    pulse(20, 130);
    drained("R3");
    check_bit("R3 synced", synced, 1'b1);
    expect_ev("S", "R2");
    pulse(20, 130);
    expect_ev("S", "R2");
    pulse(20, 130);
    drained("R2");
    check_bit("R2 synced", synced, 1'b1);

    // R4 glitch ignored
    do_reset();
    expect_ev("C", "R3");
    pulse(20, 50);
    pulse(2, 100);
    drained("R4");
    check_bit("R4 synced", synced, 1'b1);

    // R5 middle band ignored
    do_reset();
    expect_ev("C", "R3");
    pulse(20, 60);
    pulse(80, 60);
    drained("R5");
    check_bit("R5 synced", synced, 1'b1);

    // R6 / R10 sustained inhibit
    do_reset();
    expect_ev("C", "R3");
    pulse(20, 50);
    check_bit("R6 synced before", synced, 1'b1);
    expect_ev("C", "R6");
    @(negedge clk);
    inh = 1'b1;
    repeat (160) @(negedge clk);
    check_bit("R6 inhibit_active", inhibit_active, 1'b1);
    check_bit("R6 synced dropped", synced, 1'b0);
    repeat (150) @(negedge clk);
    inh = 1'b0;
    repeat (10) @(negedge clk);
    check_bit("R6 inhibit released", inhibit_active, 1'b0);
    drained("R10");

    // R7 mode 0 gap limit
    do_reset();
    mode = 2'd0;
    expect_ev("C", "R3");
    pulse(20, 40);
    check_bit("R7 mode0 early", synced, 1'b1);
    repeat (110) @(negedge clk);
    check_bit("R7 mode0 timeout", synced, 1'b0);
    drained("R7");

    // R7 mode 1 gap limit
    do_reset();
    mode = 2'd1;
    expect_ev("C", "R3");
    pulse(20, 100);
    check_bit("R7 mode1 early", synced, 1'b1);
    repeat (150) @(negedge clk);
    check_bit("R7 mode1 timeout", synced, 1'b0);
    drained("R7");

    // R7 mode 3 behaves like mode 2
    do_reset();
    mode = 2'd3;
    expect_ev("C", "R3");
    pulse(20, 250);
    check_bit("R7 mode3 early", synced, 1'b1);
    repeat (150) @(negedge clk);
    check_bit("R7 mode3 timeout", synced, 1'b0);
    drained("R7");

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule